// File: doc/BRIEF.md
# Configuration Command Mailbox

This block is a small register-mapped mailbox through which software issues configuration commands. It holds three readable words: a payload word, a command word and a completion status word. Writing the command word runs the command at once. The block strips the reserved bits and decodes the result. It then reports completion, and either pulses a shutdown or reboot request line or flags the command as unrecognised.

A variant input turns the mailbox on or off. When it is off, the three offsets act like unmapped addresses: reads return zero and writes have no effect. The block sits on a simple single-cycle register bus. It has a registered read path and two single-cycle request outputs that feed the system's power and reset logic.

Top module: `cfg_mailbox`

## Requirements
- R1: After reset the payload, command and status words read as zero, both request outputs are low, and `rdata` is zero.
- R2: The payload word at offset 0xA0 stores all 32 bits of a write and returns them on read.
- R3: A write to the command word at offset 0xA4 stores the value with bits 19:18 cleared and with bit 31 cleared, so a read never shows the start bit set.
- R4: Every command write sets the status word (offset 0xA8) to 1 (bit 0, done) when the stripped word is recognised, and to 3 (bit 0 done plus bit 1 error) when it is not.
- R5: A stripped command word of 0xC0800000 drives `shutdown_req` high for exactly the one cycle after the write. A word of 0xC0900000 does the same on `reboot_req`. Any other word raises neither output.
- R6: A write to the status word keeps only bits 1:0 of the written value, and status bits 31:2 always read as zero.
- R7: While `mbox_en` is low, reads of the three offsets return zero and writes to them change no stored state and raise no request.
- R8: `rdata` is registered. It carries the addressed word in the cycle after `rd_en`, and it is zero when `rd_en` was low or when the address is not one of the three offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mbox_en | input | 1 | Variant enable for the mailbox |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
A wrong command decode shows up on the request pins one cycle after the write. The same fault shows in the status word, which can be read back on the next access. Corrupt stripping of the command word is caught when the command word is read back: a set start bit or reserved bit appears in `rdata` one cycle after the read strobe. It is also caught when a word with reserved bits set fails to trigger its request. A leaky enable gate is caught by re-enabling the mailbox and reading the payload and status words, which must still hold their old values.

// File: rtl/cfgmb_pkg.sv
package cfgmb_pkg;
  localparam int CMD_W = 32;
  localparam logic [CMD_W-1:0] CMD_SHUTDOWN = 32'hC080_0000;
  localparam logic [CMD_W-1:0] CMD_REBOOT   = 32'hC090_0000;
  localparam logic [CMD_W-1:0] CMD_KEEP_MASK = ~((32'h3 << 18) | (32'h1 << 31));
  localparam int STAT_DONE = 0;
  localparam int STAT_ERR  = 1;

  typedef struct packed {
    logic data;
    logic ctrl;
    logic stat;
  } mb_sel_t;
endpackage

// File: rtl/cfgmb_decode.sv
module cfgmb_decode #(
  parameter int ADDR_W   = 12,
  parameter int OFF_DATA = 'hA0,
  parameter int OFF_CTRL = 'hA4,
  parameter int OFF_STAT = 'hA8
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  output cfgmb_pkg::mb_sel_t sel
);
  always_comb begin
    sel.data = enable && (addr == ADDR_W'(OFF_DATA));
    sel.ctrl = enable && (addr == ADDR_W'(OFF_CTRL));
    sel.stat = enable && (addr == ADDR_W'(OFF_STAT));
  end
endmodule

// File: rtl/cfgmb_cmd.sv
module cfgmb_cmd
  import cfgmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             stat_we,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] ctrl_q,
  output logic [1:0]       stat_q,
  output logic             shutdown_req,
  output logic             reboot_req
);
  logic [CMD_W-1:0] cmd_clean;
  logic             is_shut, is_boot;

  always_comb begin
    cmd_clean = wdata & ~(CMD_W'(32'h3) << 18);
    is_shut   = (cmd_clean == CMD_SHUTDOWN);
    is_boot   = (cmd_clean == CMD_REBOOT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q       <= '0;
      stat_q       <= '0;
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
    end else begin
      shutdown_req <= ctrl_we && is_shut;
      reboot_req   <= ctrl_we && is_boot;
      if (ctrl_we) begin
        ctrl_q           <= cmd_clean & CMD_KEEP_MASK;
        stat_q[STAT_DONE] <= 1'b1;
        stat_q[STAT_ERR]  <= !(is_shut || is_boot);
      end else if (stat_we) begin
        stat_q <= wdata[1:0];
      end
    end
  end

  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(shutdown_req && reboot_req));
  p_shut_src_r5: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> $past(ctrl_we));
  p_done_set_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> stat_q[STAT_DONE]);
  p_err_no_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !is_shut && !is_boot) |=> (stat_q[STAT_ERR] && !shutdown_req && !reboot_req));
  p_stripped_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> (ctrl_q[31] == 1'b0 && ctrl_q[19:18] == 2'b00));
endmodule

// File: rtl/cfg_mailbox.sv
module cfg_mailbox
  import cfgmb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int OFF_DATA = 'hA0,
  parameter int OFF_CTRL = 'hA4,
  parameter int OFF_STAT = 'hA8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mbox_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              shutdown_req,
  output logic              reboot_req
);
  mb_sel_t          sel;
  logic [DATA_W-1:0] data_q;
  logic [CMD_W-1:0]  ctrl_q;
  logic [1:0]        stat_q;
  logic [DATA_W-1:0] rd_mux;

  cfgmb_decode #(
    .ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA), .OFF_CTRL(OFF_CTRL), .OFF_STAT(OFF_STAT)
  ) u_dec (
    .enable(mbox_en), .addr(addr), .sel(sel)
  );

  cfgmb_cmd u_cmd (
    .clk(clk), .rst(rst),
    .ctrl_we(wr_en && sel.ctrl),
    .stat_we(wr_en && sel.stat),
    .wdata(CMD_W'(wdata)),
    .ctrl_q(ctrl_q), .stat_q(stat_q),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else if (wr_en && sel.data) data_q <= wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (sel.data) rd_mux = data_q;
    if (sel.ctrl) rd_mux = DATA_W'(ctrl_q);
    if (sel.stat) rd_mux = DATA_W'(stat_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_mux : '0;
  end

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mbox_en) |=> (!shutdown_req && !reboot_req && $stable(data_q)));
  p_rd_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
  p_onehot_sel_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel.data, sel.ctrl, sel.stat}));
endmodule

// File: tb/cfg_mailbox_test.sv
module cfg_mailbox_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst = 1, mbox_en = 1, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic shutdown_req, reboot_req;
  int n_run = 0, n_fail = 0;
  logic got_shut, got_boot;

  cfg_mailbox uut (.clk(clk), .rst(rst), .mbox_en(mbox_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    got_shut = shutdown_req; got_boot = reboot_req;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 shutdown", {31'b0, shutdown_req}, 0);
    check("R1 reboot", {31'b0, reboot_req}, 0);
    check("R1 rdata", rdata, 0);
    rd(12'hA0, v); check("R1 data", v, 0);
    rd(12'hA4, v); check("R1 ctrl", v, 0);
    rd(12'hA8, v); check("R1 status", v, 0);
  endtask

  task automatic t_data();
    logic [31:0] v;
    wr(12'hA0, 32'hDEAD_BEEF); rd(12'hA0, v); check("R2 data", v, 32'hDEAD_BEEF);
    wr(12'hA0, 32'h0123_4567); rd(12'hA0, v); check("R2 data2", v, 32'h0123_4567);
    @(negedge clk); check("R8 idle rdata", rdata, 0);
    rd(12'h0A4 + 12'h100, v); check("R8 unmapped", v, 0);
  endtask

  task automatic t_cmds();
    logic [31:0] v;
    wr(12'hA4, 32'hC080_0000);
    check("R5 shutdown pulse", {31'b0, got_shut}, 1);
    check("R5 no reboot", {31'b0, got_boot}, 0);
    @(negedge clk); check("R5 shutdown one cycle", {31'b0, shutdown_req}, 0);
    rd(12'hA8, v); check("R4 done ok", v, 1);
    rd(12'hA4, v); check("R3 start cleared", v, 32'h4080_0000);
    wr(12'hA4, 32'hC09C_0000);
    check("R5 reboot stripped", {31'b0, got_boot}, 1);
    check("R5 no shutdown", {31'b0, got_shut}, 0);
    rd(12'hA4, v); check("R3 reserved stripped", v, 32'h4090_0000);
    wr(12'hA4, 32'hFFFF_FFFF);
    check("R5 unknown no pulse", {31'b0, got_shut | got_boot}, 0);
    rd(12'hA8, v); check("R4 error", v, 3);
    rd(12'hA4, v); check("R3 unknown stored", v, 32'h7FF3_FFFF);
    wr(12'hA4, 32'h4080_0000);
    check("R5 no start bit no pulse", {31'b0, got_shut}, 0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(12'hA8, 32'hFFFF_FFFE); rd(12'hA8, v); check("R6 status mask", v, 2);
    wr(12'hA8, 32'h0); rd(12'hA8, v); check("R6 status clear", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(12'hA0, 32'h5555_AAAA);
    mbox_en = 0;
    rd(12'hA0, v); check("R7 read zero", v, 0);
    wr(12'hA0, 32'h1111_2222);
    wr(12'hA4, 32'hC080_0000);
    check("R7 no pulse", {31'b0, got_shut | got_boot}, 0);
    wr(12'hA8, 32'h3);
    mbox_en = 1;
    rd(12'hA0, v); check("R7 data kept", v, 32'h5555_AAAA);
    rd(12'hA8, v); check("R7 status kept", v, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_data(); t_cmds(); t_status(); t_disabled();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule